// File: doc/BRIEF.md
# Two-Flag Add/Subtract/Compare Unit

This block is the arithmetic slice of a processor core that keeps only two condition flags, a carry-style flag C and a zero flag Z. It performs addition, subtraction and comparison on two `WIDTH`-bit operands. Every operation comes in an unsigned form and a signed form. Both forms use one shared adder. The forms differ only in how the new C is derived from that adder's outputs. Unsigned forms report the carry or the borrow in C. Signed compare reports a corrected signed less-than in C. Signed add and signed subtract report one of two things in C, chosen at build time: the two's-complement overflow, or the sign of the mathematically exact result.

Extended forms allow multi-word arithmetic. In an extended form, the stored C acts as the carry-in or the borrow-in, and Z accumulates across the words. In a multi-word chain, only the top word uses a signed form; the lower words always use the unsigned forms. The two flags are held inside the block. Each flag is rewritten only when its own write enable is set. The next-flag outputs show the values that the coming clock edge will store.

Top module: `twoflag_alu`

Opcode `op` (4 bits) has this layout. Bits [3:2] select the class: 00 add, 01 subtract, 10 compare. Bit 1 selects the signed form. Bit 0 selects the extended form. Codes 12 to 15 are illegal.

## Requirements
- R1: For add forms `res` = D + S (+C when extended), and for subtract forms `res` = D − S (−C when extended), modulo 2^WIDTH. `res_we` is 1 only for a valid add or subtract. For compare forms it is 0.
- R2: For unsigned add forms (op 0, 1), C is the carry out. For unsigned subtract and compare forms (op 4, 5, 8, 9), C is the borrow. For op 8 (CMP), C=1 exactly when unsigned D < S.
- R3: For signed compare (op 10, 11), C=1 exactly when the exact signed value D − S (−C when extended) is negative. For op 10, C and Z are never both 1. Comparing 0x7FFFFFFF with 0xFFFFFFFF gives C=0 and Z=0.
- R4: With `CMODE` = overflow, signed add and subtract (op 2, 3, 6, 7) set C to signed overflow. 0x80000000 + 0x80000000 gives result 0 with C=1, Z=1. 0x7FFFFFFF − 0xFFFFFFFF gives 0x80000000 with C=1, Z=0.
- R5: With `CMODE` = sign, signed add and subtract set C to the sign of the exact result. The two vectors of R4 give C=1, Z=1 and C=0, Z=0.
- R6: Extended forms (odd op codes) take the stored C as carry-in for add and as borrow-in for subtract and compare.
- R7: For extended forms, the new Z is the stored Z AND (result == 0).
- R8: For non-extended forms, the new Z is (result == 0).
- R9: C is written only when `op_valid` and `wr_c` are both 1; Z only when `op_valid` and `wr_z` are both 1. Otherwise each flag keeps its value. `c_next`/`z_next` equal the flags stored at the next rising edge.
- R10: While `rst_n` is 0 at a rising edge, both flags are cleared to 0.
- R11: Illegal op codes 12 to 15 give `res_we`=0 and leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code: [3:2] class, [1] signed, [0] extended |
| opd_d | input | WIDTH | First operand D |
| opd_s | input | WIDTH | Second operand S |
| wr_c | input | 1 | Write enable for C |
| wr_z | input | 1 | Write enable for Z |
| res | output | WIDTH | Adder result |
| res_we | output | 1 | Result write-back enable |
| c_next | output | 1 | C value to be stored at the next edge |
| z_next | output | 1 | Z value to be stored at the next edge |
| c_flag | output | 1 | Stored C |
| z_flag | output | 1 | Stored Z |

## Verification
Both C modes are built side by side and are driven with the same operand patterns.

- **Boundary operands** (zero, all-ones, the most negative value, the most positive value) separate the carry/borrow meaning of C from the signed meanings.
- **The two signed vectors** tell the overflow mode apart from the sign mode.
- **Two-word chains** with and without a carry or borrow between the words show whether C feeds the upper word and whether Z accumulates.
- **Cleared write enables, dropped valid and illegal codes** show that the flags hold.
- **Random operands**, compared against a 64-bit exact-arithmetic model, cover the rest.

// File: rtl/twoflag_alu_pkg.sv
package twoflag_alu_pkg;

    // op[3:2] class, op[1] signed form, op[0] extended (chained) form
    typedef enum logic [3:0] {
        OP_ADD   = 4'h0, OP_ADDX  = 4'h1, OP_ADDS  = 4'h2, OP_ADDSX = 4'h3,
        OP_SUB   = 4'h4, OP_SUBX  = 4'h5, OP_SUBS  = 4'h6, OP_SUBSX = 4'h7,
        OP_CMP   = 4'h8, OP_CMPX  = 4'h9, OP_CMPS  = 4'hA, OP_CMPSX = 4'hB
    } alu_op_e;

    // meaning of C after signed add / subtract
    typedef enum logic {
        CMODE_OVERFLOW = 1'b0,
        CMODE_SIGN     = 1'b1
    } cmode_e;

    typedef struct packed {
        logic c;
        logic z;
    } flags_t;

    typedef struct packed {
        logic legal;
        logic is_sub;
        logic is_cmp;
        logic signed_op;
        logic extended;
    } op_dec_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import twoflag_alu_pkg::*;
(
    input  logic [3:0] op,
    output op_dec_t    dec
);
    localparam logic [1:0] CLS_SUB = 2'b01;
    localparam logic [1:0] CLS_CMP = 2'b10;
    localparam logic [1:0] CLS_BAD = 2'b11;

    always_comb begin
        dec.legal     = (op[3:2] != CLS_BAD);
        dec.is_sub    = (op[3:2] == CLS_SUB);
        dec.is_cmp    = (op[3:2] == CLS_CMP);
        dec.signed_op = op[1];
        dec.extended  = op[0];
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b_raw,
    input  logic             invert_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    always_comb begin
        b_eff = invert_b ? ~b_raw : b_raw;
        full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
        sum   = full[MSB:0];
        cout  = full[WIDTH];
        // operands agree in sign but the sum does not
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_flag_derive.sv
module alu_flag_derive
    import twoflag_alu_pkg::*;
#(
    parameter int     WIDTH = 32,
    parameter cmode_e CMODE = CMODE_OVERFLOW
) (
    input  logic             subtracting,
    input  logic             is_cmp,
    input  logic             signed_op,
    input  logic             extended,
    input  logic [WIDTH-1:0] sum,
    input  logic             cout,
    input  logic             ovf,
    input  logic             z_prev,
    output logic             c_calc,
    output logic             z_calc
);
    localparam int MSB = WIDTH - 1;

    logic c_unsigned;
    logic exact_neg;
    logic c_signed_arith;
    logic zero;

    // true sign of the exact result: stored sign bit corrected by overflow
    assign exact_neg  = sum[MSB] ^ ovf;
    // a subtract is done as D + ~S + 1, so the borrow is the inverted carry
    assign c_unsigned = subtracting ? ~cout : cout;
    assign zero       = (sum == '0);

    generate
        if (CMODE == CMODE_SIGN) begin : g_sign_mode
            assign c_signed_arith = exact_neg;
        end else begin : g_ovf_mode
            assign c_signed_arith = ovf;
        end
    endgenerate

    always_comb begin
        if (!signed_op)  c_calc = c_unsigned;
        else if (is_cmp) c_calc = exact_neg;
        else             c_calc = c_signed_arith;
        z_calc = extended ? (z_prev & zero) : zero;
    end
endmodule

// File: rtl/twoflag_alu.sv
module twoflag_alu
    import twoflag_alu_pkg::*;
#(
    parameter int     WIDTH = 32,
    parameter cmode_e CMODE = CMODE_OVERFLOW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] opd_d,
    input  logic [WIDTH-1:0] opd_s,
    input  logic             wr_c,
    input  logic             wr_z,
    output logic [WIDTH-1:0] res,
    output logic             res_we,
    output logic             c_next,
    output logic             z_next,
    output logic             c_flag,
    output logic             z_flag
);
    localparam int MSB = WIDTH - 1;

    op_dec_t          dec;
    flags_t           flags_d, flags_q;
    logic             subtracting;
    logic             carry_in;
    logic             fire;
    logic [WIDTH-1:0] sum;
    logic             cout, ovf;
    logic             c_calc, z_calc;

    alu_op_decode i_dec (
        .op  (op),
        .dec (dec)
    );

    assign subtracting = dec.is_sub | dec.is_cmp;
    // extended forms feed the stored C in: as carry for add, as borrow for sub
    assign carry_in    = dec.extended ? (subtracting ? ~flags_q.c : flags_q.c)
                                      : subtracting;
    assign fire        = op_valid & dec.legal;

    alu_adder #(.WIDTH(WIDTH)) i_add (
        .a        (opd_d),
        .b_raw    (opd_s),
        .invert_b (subtracting),
        .cin      (carry_in),
        .sum      (sum),
        .cout     (cout),
        .ovf      (ovf)
    );

    alu_flag_derive #(.WIDTH(WIDTH), .CMODE(CMODE)) i_flags (
        .subtracting (subtracting),
        .is_cmp      (dec.is_cmp),
        .signed_op   (dec.signed_op),
        .extended    (dec.extended),
        .sum         (sum),
        .cout        (cout),
        .ovf         (ovf),
        .z_prev      (flags_q.z),
        .c_calc      (c_calc),
        .z_calc      (z_calc)
    );

    always_comb begin
        flags_d = flags_q;
        if (fire && wr_c) flags_d.c = c_calc;
        if (fire && wr_z) flags_d.z = z_calc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign res    = sum;
    assign res_we = fire & ~dec.is_cmp;
    assign c_next = flags_d.c;
    assign z_next = flags_d.z;
    assign c_flag = flags_q.c;
    assign z_flag = flags_q.z;

    // ---------------- assertions ----------------
    logic signed [WIDTH:0] chk_wide;
    logic                  chk_out_of_range;
    assign chk_wide = $signed({opd_d[MSB], opd_d}) + $signed({opd_s[MSB], opd_s});
    assign chk_out_of_range = chk_wide[WIDTH] != chk_wide[MSB];

    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!c_flag && !z_flag));

    a_r9_c_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && wr_c) |=> $stable(c_flag));

    a_r9_z_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && wr_z) |=> $stable(z_flag));

    a_r1_cmp_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (op[3:2] == 2'b10) |-> !res_we);

    a_r11_illegal_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (op[3:2] == 2'b11) |-> (!res_we && c_next == c_flag && z_next == z_flag));

    a_r2_cmp_unsigned_lt: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMP) |-> (c_calc == (opd_d < opd_s)));

    a_r3_cmps_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CMPS) |-> !(c_calc && z_calc));

    generate
        if (CMODE == CMODE_SIGN) begin : g_chk_sign
            a_r5_adds_sign: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_ADDS) |-> (c_calc == chk_wide[WIDTH]));
        end else begin : g_chk_ovf
            a_r4_adds_overflow: assert property (@(posedge clk) disable iff (!rst_n)
                (op == OP_ADDS) |-> (c_calc == chk_out_of_range));
        end
    endgenerate

endmodule

// File: tb/test_twoflag_alu.sv
module test_twoflag_alu;
    import twoflag_alu_pkg::*;

    localparam time PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op;
    logic [31:0] opd_d, opd_s;
    logic        wr_c, wr_z;

    logic [31:0] res_w   [2];
    logic        we_w    [2];
    logic        cn_w    [2];
    logic        zn_w    [2];
    logic        cf_w    [2];
    logic        zf_w    [2];

    // model state per mode (0 = overflow, 1 = sign)
    logic        mc [2];
    logic        mz [2];

    int n_chk  = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    twoflag_alu #(.WIDTH(32), .CMODE(CMODE_OVERFLOW)) i_twoflag_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
        .opd_d(opd_d), .opd_s(opd_s), .wr_c(wr_c), .wr_z(wr_z),
        .res(res_w[0]), .res_we(we_w[0]), .c_next(cn_w[0]), .z_next(zn_w[0]),
        .c_flag(cf_w[0]), .z_flag(zf_w[0])
    );

    twoflag_alu #(.WIDTH(32), .CMODE(CMODE_SIGN)) i_twoflag_alu_sign (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
        .opd_d(opd_d), .opd_s(opd_s), .wr_c(wr_c), .wr_z(wr_z),
        .res(res_w[1]), .res_we(we_w[1]), .c_next(cn_w[1]), .z_next(zn_w[1]),
        .c_flag(cf_w[1]), .z_flag(zf_w[1])
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // exact-arithmetic reference for one mode
    task automatic model(input int m, input logic [3:0] o, input logic [31:0] d,
                         input logic [31:0] s, input logic cp, input logic zp,
                         output logic [31:0] r, output logic c, output logic z,
                         output logic we, output logic legal);
        longint ud, us, u, sd, ss, sx;
        logic   cin, carry_or_borrow;
        ud = longint'({32'h0, d});
        us = longint'({32'h0, s});
        sd = longint'($signed(d));
        ss = longint'($signed(s));
        legal = (o < 4'd12);
        cin   = o[0] ? cp : 1'b0;
        if (o[3:2] == 2'b00) begin
            u  = ud + us + longint'(cin);
            sx = sd + ss + longint'(cin);
            carry_or_borrow = u[32];
        end else begin
            u  = ud - us - longint'(cin);
            sx = sd - ss - longint'(cin);
            carry_or_borrow = (u < 0);
        end
        r = u[31:0];
        if (!o[1])                c = carry_or_borrow;
        else if (o[3:2] == 2'b10) c = (sx < 0);
        else if (m == 0)          c = (sx > 64'sd2147483647) || (sx < -64'sd2147483648);
        else                      c = (sx < 0);
        z  = o[0] ? (zp & (r == 32'h0)) : (r == 32'h0);
        we = legal && (o[3:2] != 2'b10);
    endtask

    task automatic run_op(input logic [3:0] o, input logic [31:0] d, input logic [31:0] s,
                          input logic wc, input logic wz, input logic v, input string tag);
        logic [31:0] r;
        logic c, z, we, legal;
        logic ec [2];
        logic ez [2];
        @(negedge clk);
        op = o; opd_d = d; opd_s = s; wr_c = wc; wr_z = wz; op_valid = v;
        #1;
        for (int m = 0; m < 2; m++) begin
            model(m, o, d, s, mc[m], mz[m], r, c, z, we, legal);
            ec[m] = (v && legal && wc) ? c : mc[m];
            ez[m] = (v && legal && wz) ? z : mz[m];
            if (legal && v && (o[3:2] != 2'b10))
                chk(res_w[m] == r, tag, "res", res_w[m], r);
            chk(we_w[m] == (v && we), tag, "res_we", 32'(we_w[m]), 32'(v && we));
            chk(cn_w[m] == ec[m], tag, m ? "c_next(sign)" : "c_next(ovf)", 32'(cn_w[m]), 32'(ec[m]));
            chk(zn_w[m] == ez[m], tag, "z_next", 32'(zn_w[m]), 32'(ez[m]));
        end
        @(posedge clk);
        #1;
        for (int m = 0; m < 2; m++) begin
            mc[m] = ec[m];
            mz[m] = ez[m];
            chk(cf_w[m] == mc[m], tag, "c_flag", 32'(cf_w[m]), 32'(mc[m]));
            chk(zf_w[m] == mz[m], tag, "z_flag", 32'(zf_w[m]), 32'(mz[m]));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0;
        @(posedge clk); #1;
        for (int m = 0; m < 2; m++) begin
            mc[m] = 1'b0; mz[m] = 1'b0;
            chk(cf_w[m] == 1'b0, "R10", "c_flag after reset", 32'(cf_w[m]), 0);
            chk(zf_w[m] == 1'b0, "R10", "z_flag after reset", 32'(zf_w[m]), 0);
            chk(we_w[m] == 1'b0, "R10", "res_we idle", 32'(we_w[m]), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_unsigned();
        run_op(OP_ADD, 32'hFFFF_FFFF, 32'h1, 1, 1, 1, "R1 R2 R8 add carry");
        run_op(OP_ADD, 32'h1234_0000, 32'h0000_5678, 1, 1, 1, "R1 R2 R8 add plain");
        run_op(OP_SUB, 32'd3, 32'd5, 1, 1, 1, "R1 R2 sub borrow");
        run_op(OP_CMP, 32'd5, 32'd5, 1, 1, 1, "R2 R8 cmp equal");
        run_op(OP_CMP, 32'd1, 32'd2, 1, 1, 1, "R1 R2 cmp less");
        run_op(OP_CMP, 32'hFFFF_FFFF, 32'd0, 1, 1, 1, "R2 cmp greater");
    endtask

    task automatic t_signed_vectors();
        run_op(OP_ADDS, 32'h8000_0000, 32'h8000_0000, 1, 1, 1, "R4 R5 adds min+min");
        run_op(OP_CMPS, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 1, 1, "R3 cmps max vs -1");
        run_op(OP_SUBS, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 1, 1, "R4 R5 subs max-(-1)");
        run_op(OP_CMPS, 32'hFFFF_FFFF, 32'h0000_0001, 1, 1, 1, "R3 cmps -1 vs 1");
        run_op(OP_CMPS, 32'h8000_0000, 32'h8000_0000, 1, 1, 1, "R3 cmps equal");
        run_op(OP_ADDS, 32'h0000_0005, 32'hFFFF_FFF0, 1, 1, 1, "R4 R5 adds no overflow");
    endtask

    task automatic t_extended();
        run_op(OP_ADD,   32'hFFFF_FFFF, 32'h1, 1, 1, 1, "R6 low word carry");
        run_op(OP_ADDX,  32'h0, 32'h0, 1, 1, 1, "R6 R7 high word takes carry");
        run_op(OP_SUB,   32'h0, 32'h0, 1, 1, 1, "R7 low word zero");
        run_op(OP_SUBX,  32'h5, 32'h5, 1, 1, 1, "R7 whole value zero");
        run_op(OP_SUB,   32'h0, 32'h1, 1, 1, 1, "R6 low word borrow");
        run_op(OP_SUBX,  32'h5, 32'h5, 1, 1, 1, "R6 R7 high word takes borrow");
        run_op(OP_CMP,   32'h0, 32'h1, 1, 1, 1, "R6 low compare borrow");
        run_op(OP_CMPSX, 32'h0, 32'h0, 1, 1, 1, "R3 R6 signed top compare");
        run_op(OP_ADD,   32'h1, 32'h1, 1, 1, 1, "R7 low nonzero");
        run_op(OP_ADDSX, 32'h0, 32'h0, 1, 1, 1, "R5 R7 signed top add");
    endtask

    task automatic t_enables();
        run_op(OP_ADD, 32'hFFFF_FFFF, 32'h1, 0, 1, 1, "R9 C disabled");
        run_op(OP_SUB, 32'h0, 32'h1, 1, 0, 1, "R9 Z disabled");
        run_op(OP_ADD, 32'h0, 32'h0, 1, 1, 0, "R9 valid low");
        run_op(OP_SUBX, 32'h0, 32'h0, 0, 0, 1, "R9 both disabled");
    endtask

    task automatic t_illegal();
        for (int k = 12; k < 16; k++)
            run_op(4'(k), 32'hFFFF_FFFF, 32'h1, 1, 1, 1, "R11 illegal code");
    endtask

    task automatic t_random();
        for (int k = 0; k < 300; k++)
            run_op(4'($urandom_range(0, 11)), $urandom, $urandom,
                   1'($urandom), 1'($urandom), 1'b1, "R1 R6 random");
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op = '0; opd_d = '0; opd_s = '0;
        wr_c = 1'b0; wr_z = 1'b0;
        for (int m = 0; m < 2; m++) begin mc[m] = 1'b0; mz[m] = 1'b0; end
        repeat (2) @(posedge clk);
        t_reset();
        t_unsigned();
        t_signed_vectors();
        t_extended();
        t_enables();
        t_illegal();
        t_random();
        run_op(OP_ADD, 32'hFFFF_FFFF, 32'h1, 1, 1, 1, "R10 preset flags");
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule